// File: doc/BRIEF.md
# Indexed Auto-Increment Display Memory Port

This block lets a narrow 8-bit host bus reach a 9600-byte display memory through three I/O registers. It does not map every byte into the host address space. The host sets a 14-bit pointer by writing its low byte and its upper six bits into two separate registers. It then moves bytes in or out through a single data-port register. The pointer steps forward by one after every data-port access, so a block copy needs only one pointer setup followed by a run of port accesses.

All host inputs are sampled on the block clock. An access begins when the sampled chip select overlaps a sampled read or write strobe. The action takes effect when that overlap ends. The memory itself lives outside the block. The block supplies the memory address, a one-cycle write enable and the write data, and it returns the memory's read data on the host read bus when the data port is addressed.

Top module: `idx_mem_port`

## Requirements
- R1: While reset is asserted, and right after it, the pointer (`memAddr`) is 0, `memWe` is low, and both pointer registers read back as 0.
- R2: A write to register address 5'b10010 loads pointer bits 7:0 from the data byte and leaves bits 13:8 unchanged.
- R3: A write to register address 5'b10100 loads pointer bits 13:8 from data bits 5:0 and leaves bits 7:0 unchanged.
- R4: A read of 5'b10010 returns pointer bits 7:0. A read of 5'b10100 returns pointer bits 13:8 in bits 5:0, with bits 7:6 always 0.
- R5: A write to the data port (5'b10000) causes exactly one `memWe` cycle. In that cycle `memAddr` is the pointer value held before the access and `memWData` is the written byte.
- R6: A read of the data port returns the memory byte stored at the pointer value held before the access.
- R7: Each data-port access, read or write, advances the pointer by exactly one, however many cycles the strobe overlap lasts.
- R8: When the pointer is at 0x257F or above, the advance after a data-port access sets it to 0.
- R9: Nothing happens unless chip select and a strobe are both low: a strobe without chip select, or chip select without a strobe, neither writes memory nor moves the pointer.
- R10: A write to any register address other than the three above writes no memory and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioCsN | input | 1 | Register chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| regAddr | input | 5 | Register address |
| busIn | input | 8 | Host write data |
| rdData | output | 8 | Host read data |
| memAddr | output | 14 | Display memory address (current pointer) |
| memWe | output | 1 | Display memory write enable, one cycle per port write |
| memWData | output | 8 | Display memory write data |
| memRData | input | 8 | Display memory read data (combinational from memAddr) |

## Verification
The bench aims at the step from 0x257F. A design that wraps on a power of two would show 0x2580 there, or would keep counting. Strobes are held for one cycle and for several cycles. A design that advances on every overlapping cycle instead of once per access would skip addresses and write the same byte more than once, and the scoreboard would flag the extra or misplaced write pulses. Each half of the pointer is written alone and both halves are read back, which catches a load that disturbs the other half and high-part reads that leak bits 7:6. Strobes without chip select, chip select without strobes, and writes to unused addresses are each followed by a pointer check, so a design that acts on them would show a moved pointer or a stray write.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;
  // Strobes from the access sequencer to the pointer datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic memWrite;
    logic advance;
  } portStrobe_t;
endpackage

// File: rtl/idx_port_ctrl.sv
module idx_port_ctrl
  import idx_port_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 8,
  parameter logic [ADDR_W-1:0] DP_ADDR = 5'b10000,
  parameter logic [ADDR_W-1:0] LO_ADDR = 5'b10010,
  parameter logic [ADDR_W-1:0] HI_ADDR = 5'b10100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioCsN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] busIn,
  output portStrobe_t       strb,
  output logic [DATA_W-1:0] heldData,
  output logic [ADDR_W-1:0] liveAddr
);
  logic csQ, wrQ, rdQ;
  logic [DATA_W-1:0] dataQ;
  logic [ADDR_W-1:0] heldAddr;
  logic heldWrite;
  logic prevActive;
  logic active;
  logic trail;

  // Input capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ      <= 1'b1;
      wrQ      <= 1'b1;
      rdQ      <= 1'b1;
      liveAddr <= '0;
      dataQ    <= '0;
    end else begin
      csQ      <= ioCsN;
      wrQ      <= wrN;
      rdQ      <= rdN;
      liveAddr <= regAddr;
      dataQ    <= busIn;
    end
  end

  assign active = !csQ && (!wrQ || !rdQ);
  assign trail  = prevActive && !active;

  // Hold the access parameters while the overlap lasts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      heldAddr   <= '0;
      heldData   <= '0;
      heldWrite  <= 1'b0;
    end else begin
      prevActive <= active;
      if (active) begin
        heldAddr  <= liveAddr;
        heldData  <= dataQ;
        heldWrite <= !wrQ;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadLo   = trail && heldWrite && (heldAddr == LO_ADDR);
    strb.loadHi   = trail && heldWrite && (heldAddr == HI_ADDR);
    strb.memWrite = trail && heldWrite && (heldAddr == DP_ADDR);
    strb.advance  = trail && (heldAddr == DP_ADDR);
  end
endmodule

// File: rtl/idx_port_dp.sv
module idx_port_dp
  import idx_port_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 14,
  parameter int MEM_DEPTH = 9600,
  parameter logic [ADDR_W-1:0] DP_ADDR = 5'b10000,
  parameter logic [ADDR_W-1:0] LO_ADDR = 5'b10010,
  parameter logic [ADDR_W-1:0] HI_ADDR = 5'b10100
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strb,
  input  logic [DATA_W-1:0] heldData,
  input  logic [ADDR_W-1:0] liveAddr,
  input  logic [DATA_W-1:0] memRData,
  output logic [IDX_W-1:0]  memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWData,
  output logic [DATA_W-1:0] rdData
);
  localparam int HI_W = IDX_W - DATA_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MEM_DEPTH - 1);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] ptrStep;

  assign ptrStep = (ptr >= LAST_IDX) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.loadLo) begin
      ptr[DATA_W-1:0] <= heldData;
    end else if (strb.loadHi) begin
      ptr[IDX_W-1:DATA_W] <= heldData[HI_W-1:0];
    end else if (strb.advance) begin
      ptr <= ptrStep;
    end
  end

  assign memAddr  = ptr;
  assign memWe    = strb.memWrite;
  assign memWData = heldData;

  always_comb begin
    rdData = '0;
    if (liveAddr == DP_ADDR)      rdData = memRData;
    else if (liveAddr == LO_ADDR) rdData = ptr[DATA_W-1:0];
    else if (liveAddr == HI_ADDR) rdData = {{(DATA_W-HI_W){1'b0}}, ptr[IDX_W-1:DATA_W]};
  end
endmodule

// File: rtl/idx_mem_port.sv
module idx_mem_port
  import idx_port_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 14,
  parameter int MEM_DEPTH = 9600,
  parameter logic [ADDR_W-1:0] DP_ADDR = 5'b10000,
  parameter logic [ADDR_W-1:0] LO_ADDR = 5'b10010,
  parameter logic [ADDR_W-1:0] HI_ADDR = 5'b10100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioCsN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData
);
  portStrobe_t       strb;
  logic [DATA_W-1:0] heldData;
  logic [ADDR_W-1:0] liveAddr;

  idx_port_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DP_ADDR(DP_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ioCsN(ioCsN), .wrN(wrN), .rdN(rdN),
    .regAddr(regAddr), .busIn(busIn),
    .strb(strb), .heldData(heldData), .liveAddr(liveAddr)
  );

  idx_port_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .MEM_DEPTH(MEM_DEPTH),
    .DP_ADDR(DP_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .heldData(heldData),
    .liveAddr(liveAddr), .memRData(memRData),
    .memAddr(memAddr), .memWe(memWe), .memWData(memWData), .rdData(rdData)
  );
endmodule

// File: rtl/idx_mem_port_chk.sv
module idx_mem_port_chk #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 14,
  parameter int MEM_DEPTH = 9600,
  parameter logic [ADDR_W-1:0] HI_ADDR = 5'b10100
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioCsN,
  input logic              rdN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [IDX_W-1:0]  memAddr,
  input logic              memWe
);
  localparam int HI_W = IDX_W - DATA_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MEM_DEPTH - 1);

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (memAddr == '0) && !memWe);

  // R5
  single_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R7
  we_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr < LAST_IDX) |=> memAddr == $past(memAddr) + 1'b1);

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr >= LAST_IDX) |=> memAddr == '0);

  // R9
  no_select_no_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && $past(ioCsN) && $past(ioCsN, 2)) |-> !memWe);

  // R4
  hi_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && $past(!ioCsN && !rdN && regAddr == HI_ADDR))
      |-> rdData[DATA_W-1:HI_W] == '0);
endmodule

bind idx_mem_port idx_mem_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
  .MEM_DEPTH(MEM_DEPTH), .HI_ADDR(HI_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .ioCsN(ioCsN), .rdN(rdN), .regAddr(regAddr),
  .rdData(rdData), .memAddr(memAddr), .memWe(memWe)
);

// File: tb/idx_mem_port_tb_top.sv
module idx_mem_port_tb_top;
  localparam logic [4:0] DP = 5'b10000;
  localparam logic [4:0] LO = 5'b10010;
  localparam logic [4:0] HI = 5'b10100;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic ioCsN = 1'b1, wrN = 1'b1, rdN = 1'b1;
  logic [4:0]  regAddr = '0;
  logic [7:0]  busIn = '0;
  logic [7:0]  rdData, memWData, memRData;
  logic [13:0] memAddr;
  logic        memWe;

  int checks = 0;
  int errors = 0;
  logic rdSample = 1'b0;
  string rdTag = "";

  typedef struct packed { logic [13:0] addr; logic [7:0] data; } wrItem_t;
  wrItem_t wrQueue[$];
  logic [7:0] rdQueue[$];

  logic [7:0] memModel [256];

  always #10 clk = ~clk;

  idx_mem_port dut_i (
    .clk(clk), .rstN(rstN), .ioCsN(ioCsN), .wrN(wrN), .rdN(rdN),
    .regAddr(regAddr), .busIn(busIn), .rdData(rdData),
    .memAddr(memAddr), .memWe(memWe), .memWData(memWData),
    .memRData(memRData)
  );

  assign memRData = memModel[memAddr[7:0]];

  initial for (int i = 0; i < 256; i++) memModel[i] = 8'h00;

  always @(posedge clk) if (rstN && memWe) memModel[memAddr[7:0]] <= memWData;

  // Monitor: compares produced writes and sampled reads against the queues
  always @(negedge clk) begin
    if (rstN && memWe) begin
      checks++;
      if (wrQueue.size() == 0) begin
        errors++;
        $display("FAIL R5/R9/R10: unexpected write addr=%h data=%h expected none",
                 memAddr, memWData);
      end else begin
        wrItem_t e;
        e = wrQueue.pop_front();
        if (memAddr !== e.addr || memWData !== e.data) begin
          errors++;
          $display("FAIL R5: write addr=%h data=%h expected addr=%h data=%h",
                   memAddr, memWData, e.addr, e.data);
        end
      end
    end
    if (rdSample) begin
      logic [7:0] e;
      checks++;
      e = rdQueue.pop_front();
      if (rdData !== e) begin
        errors++;
        $display("FAIL %s: rdData=%h expected %h", rdTag, rdData, e);
      end
    end
  end

  task automatic hostWrite(input logic [4:0] a, input logic [7:0] d, input int hold);
    @(posedge clk); #5;
    regAddr = a; busIn = d; ioCsN = 1'b0; wrN = 1'b0;
    repeat (hold) @(posedge clk);
    #5; ioCsN = 1'b1; wrN = 1'b1;
    repeat (2) @(posedge clk);
    #5;
  endtask

  task automatic hostRead(input logic [4:0] a, input logic [7:0] exp, input string tag, input int hold);
    rdQueue.push_back(exp);
    @(posedge clk); #5;
    regAddr = a; ioCsN = 1'b0; rdN = 1'b0;
    @(posedge clk); #5;
    rdTag = tag; rdSample = 1'b1;
    @(negedge clk); #1;
    rdSample = 1'b0;
    repeat (hold) @(posedge clk);
    #5; ioCsN = 1'b1; rdN = 1'b1;
    repeat (2) @(posedge clk);
    #5;
  endtask

  task automatic portWrite(input logic [13:0] at, input logic [7:0] d, input int hold);
    wrQueue.push_back({at, d});
    hostWrite(DP, d, hold);
  endtask

  task automatic checkPtr(input logic [13:0] exp, input string tag);
    checks++;
    if (memAddr !== exp) begin
      errors++;
      $display("FAIL %s: memAddr=%h expected %h", tag, memAddr, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    checkPtr(14'h0000, "R1 pointer in reset");
    checks++;
    if (memWe !== 1'b0) begin
      errors++;
      $display("FAIL R1: memWe=%b expected 0", memWe);
    end
    rstN = 1'b1;
    repeat (2) @(posedge clk); #5;
    hostRead(LO, 8'h00, "R1 low after reset", 1);
    hostRead(HI, 8'h00, "R1 high after reset", 1);

    // R2 / R3: halves written alone
    hostWrite(LO, 8'h34, 2);  checkPtr(14'h0034, "R2 low load");
    hostWrite(HI, 8'h12, 2);  checkPtr(14'h1234, "R3 high load");
    hostWrite(LO, 8'h56, 1);  checkPtr(14'h1256, "R2 high kept");
    hostWrite(HI, 8'hFF, 3);  checkPtr(14'h3F56, "R3 low kept, upper bits dropped");
    // R4: readback
    hostRead(HI, 8'h3F, "R4 high readback top zero", 1);
    hostRead(LO, 8'h56, "R4 low readback", 1);
    hostWrite(HI, 8'h00, 2);  checkPtr(14'h0056, "R3 high clear");

    // R5 / R7: data port writes, short and long strobes
    hostWrite(LO, 8'h10, 2);
    portWrite(14'h0010, 8'hA1, 1);  checkPtr(14'h0011, "R7 advance after write");
    portWrite(14'h0011, 8'hB2, 2);  checkPtr(14'h0012, "R7 advance after write");
    portWrite(14'h0012, 8'hC3, 6);  checkPtr(14'h0013, "R7 single advance long strobe");

    // R6 / R7: data port reads
    hostWrite(LO, 8'h10, 2);
    hostRead(DP, 8'hA1, "R6 read pre-advance byte", 1);
    checkPtr(14'h0011, "R7 advance after read");
    hostRead(DP, 8'hB2, "R6 read next byte", 2);
    hostRead(DP, 8'hC3, "R6 read long strobe", 7);
    checkPtr(14'h0013, "R7 single advance long read");

    // R8: wrap at last location
    hostWrite(LO, 8'h7F, 2);
    hostWrite(HI, 8'h25, 2);
    checkPtr(14'h257F, "R8 pointer at last");
    portWrite(14'h257F, 8'h5A, 2);
    checkPtr(14'h0000, "R8 wrap to zero");
    hostRead(LO, 8'h00, "R8 low after wrap", 1);
    hostRead(HI, 8'h00, "R8 high after wrap", 1);
    hostRead(DP, 8'h00, "R6 read at zero", 1);
    checkPtr(14'h0001, "R7 advance from zero");

    // R9: strobes without select, select without strobes
    @(posedge clk); #5;
    regAddr = DP; busIn = 8'hEE; wrN = 1'b0;
    repeat (3) @(posedge clk); #5; wrN = 1'b1;
    rdN = 1'b0;
    repeat (3) @(posedge clk); #5; rdN = 1'b1;
    ioCsN = 1'b0;
    repeat (3) @(posedge clk); #5; ioCsN = 1'b1;
    repeat (3) @(posedge clk); #5;
    checkPtr(14'h0001, "R9 no access without overlap");

    // R10: unused register address
    hostWrite(5'b00110, 8'hEE, 2);
    hostWrite(5'b10110, 8'h77, 2);
    checkPtr(14'h0001, "R10 unused address ignored");

    repeat (4) @(posedge clk); #5;
    checks++;
    if (wrQueue.size() != 0) begin
      errors++;
      $display("FAIL R5: %0d writes missing, expected 0", wrQueue.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule